// File: doc/BRIEF.md
# SPD EEPROM I2C Target with Half Select

This block is an I2C target that models a 512-byte serial presence detect memory of the kind found on memory modules. The storage is split into two 256-byte halves, and a one-bit half-select register decides which half the bus can reach. An 8-bit pointer addresses a byte inside the selected half. The block supports random reads, current-address and sequential reads, and row-bounded writes of 1 to 16 bytes. SCL and SDA are synchronised to the system clock before START and STOP are detected. SDA is driven only as an open-drain pull-down.

The memory device address is the 4-bit type code 1010 followed by three strap inputs. Two global commands use their own address bytes and ignore the straps. 0x6C selects half 0 and 0x6E selects half 1. Each of them is followed by two dummy bytes, and the block acknowledges both. A separate unit supplies four lock bits, one for each 128-byte block. A write into a locked block is acknowledged but changes nothing.

The protocol engine has eight states: IDLE, ADDR, PTR, WDATA, DUMMY, ACK, RDATA and RACK.
- START enters ADDR from any state. STOP returns to IDLE from any state.
- ADDR goes to ACK on a device-address match or a half-select command. Any other address goes to IDLE.
- After ACK, the engine continues into the state chosen when the byte was decoded:
  - PTR after a memory write address;
  - RDATA after a memory read address;
  - DUMMY after a half-select command;
  - WDATA after a pointer byte or a data byte.
- PTR, WDATA and DUMMY go to ACK once eight bits have been received.
- RDATA goes to RACK once eight bits have been sent.
- From RACK, a controller ACK loops back to RDATA and a controller NACK goes to IDLE.

Top module: `spd_i2c_target`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal {1010, addr_strap[2:0]}. Bit 0 selects read (1) or write (0). Any other address byte (except a half-select command) is not acknowledged, and SDA stays released until the next START.
- R2: Address byte 0x6C selects half 0 and 0x6E selects half 1, for any strap value. Bit 1 of the address byte is the half number. The command and both following dummy bytes are acknowledged.
- R3: In a write transaction, the first data byte after the address is loaded into the pointer. A following read transaction returns the byte at {half, pointer}.
- R4: During a read, the pointer advances by one after each byte sent. It wraps from 0xFF to 0x00 inside the selected half and never reaches the other half.
- R5: Each write data byte is stored at {half, pointer} and acknowledged. After each byte, only pointer bits [3:0] advance, so writes wrap inside the aligned 16-byte row.
- R6: Lock bit index {half, pointer[7]} covers one 128-byte block: 0 is half 0 low, 1 is half 0 high, 2 is half 1 low and 3 is half 1 high. A write into a locked block is acknowledged and leaves storage unchanged. The pointer still advances.
- R7: After reset, the selected half is 0, the pointer is 0, every stored byte is 0x00 and SDA is released.
- R8: A read ends when the controller answers a data byte with NACK; the target then releases SDA. A later read with no pointer byte continues at the byte after the last one sent.
- R9: A START that arrives in the middle of a byte discards the partial byte. Decoding restarts with a fresh address byte.
- R10: The target changes its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| addr_strap | input | 3 | Low three bits of the memory device address |
| blk_lock | input | 4 | Per-block write lock; bit index {half, pointer[7]} |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
A wrong half-select bit or pointer shows up as wrong read data. The first byte after a pointer byte exposes a bad load. A byte past 0xFF or past a row end exposes bad wrap logic, and it does so within one byte time of the error. A state machine stuck in the wrong state shows up at the next acknowledge slot, as a missing or unexpected pull-down. A lock decode error shows up only on the read-back that follows the write. For that reason, every protected write in the bench is followed by a read of the same row.

// File: rtl/spd_pkg.sv
package spd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDATA,
        ST_DUMMY,
        ST_ACK,
        ST_RDATA,
        ST_RACK
    } spd_state_t;

    // upper nibble of the memory device address
    localparam logic [3:0] DEV_TYPE = 4'b1010;
    // bits [7:2] of a half-select command; bit 1 carries the half number
    localparam logic [5:0] HSEL_TAG = 6'b011011;

endpackage

// File: rtl/spd_sync.sv
module spd_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/spd_store.sv
module spd_store #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/spd_i2c_target.sv
module spd_i2c_target
    import spd_pkg::*;
#(
    parameter int PTR_W       = 8,
    parameter int ROW_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] addr_strap,
    input  logic [3:0] blk_lock,
    output logic       sda_pull
);

    localparam int          MEM_AW   = PTR_W + 1;
    localparam logic [3:0]  BIT_LAST = 4'd8;

    logic [1:0]       sync_q;
    logic             scl_s, sda_s, scl_q, sda_q;
    logic             scl_rise, scl_fall, start_det, stop_det;
    spd_state_t       state, after_ack;
    logic [7:0]       shreg, txreg;
    logic [3:0]       bitcnt;
    logic [PTR_W-1:0] ptr;
    logic             half;
    logic             ctrl_nack;
    logic             wr_req, prot_hit, mem_we;
    logic [7:0]       rd_data;
    logic [1:0]       blk_idx;

    spd_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (sync_q)
    );

    assign scl_s     = sync_q[1];
    assign sda_s     = sync_q[0];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

    assign blk_idx  = {half, ptr[PTR_W-1]};
    assign prot_hit = blk_lock[blk_idx];
    assign wr_req   = (state == ST_WDATA) && scl_fall && (bitcnt == BIT_LAST);
    assign mem_we   = wr_req & ~prot_hit;

    spd_store #(.AW(MEM_AW), .DW(8)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr ({half, ptr}),
        .wdata (shreg),
        .raddr ({half, ptr}),
        .rdata (rd_data)
    );

    // state register and protocol datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
            state     <= ST_IDLE;
            after_ack <= ST_IDLE;
            shreg     <= '0;
            txreg     <= '0;
            bitcnt    <= '0;
            ptr       <= '0;
            half      <= 1'b0;
            ctrl_nack <= 1'b0;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
            if (start_det) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                bitcnt <= '0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_ADDR, ST_PTR, ST_WDATA, ST_DUMMY: begin
                        if (scl_rise && bitcnt != BIT_LAST) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == BIT_LAST) begin
                            bitcnt <= '0;
                            state  <= ST_ACK;
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == {DEV_TYPE, addr_strap}) begin
                                    after_ack <= shreg[0] ? ST_RDATA : ST_PTR;
                                end else if (shreg[7:2] == HSEL_TAG && !shreg[0]) begin
                                    half      <= shreg[1];
                                    after_ack <= ST_DUMMY;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_PTR) begin
                                ptr       <= shreg[PTR_W-1:0];
                                after_ack <= ST_WDATA;
                            end else if (state == ST_WDATA) begin
                                ptr       <= {ptr[PTR_W-1:ROW_W], ptr[ROW_W-1:0] + 1'b1};
                                after_ack <= ST_WDATA;
                            end else begin
                                after_ack <= ST_DUMMY;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            state  <= after_ack;
                            bitcnt <= '0;
                            if (after_ack == ST_RDATA) begin
                                txreg <= rd_data;
                                ptr   <= ptr + 1'b1;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == BIT_LAST) begin
                                state  <= ST_RACK;
                                bitcnt <= '0;
                            end else begin
                                txreg <= {txreg[6:0], 1'b0};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            ctrl_nack <= sda_s;
                        end else if (scl_fall) begin
                            if (ctrl_nack) begin
                                state <= ST_IDLE;
                            end else begin
                                state <= ST_RDATA;
                                txreg <= rd_data;
                                ptr   <= ptr + 1'b1;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // open-drain output
    always_comb begin
        unique case (state)
            ST_ACK:   sda_pull = 1'b1;
            ST_RDATA: sda_pull = ~txreg[7];
            default:  sda_pull = 1'b0;
        endcase
    end

    // R10: the pull-down only switches on after SCL is seen low
    p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);

    // R9: a START always restarts address decoding
    p_start_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR));

    // R5: a data write never moves the pointer out of its 16-byte row
    p_row_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> (ptr[PTR_W-1:ROW_W] == $past(ptr[PTR_W-1:ROW_W])));

    // R2 / R4: the half only changes when an address byte is decoded
    p_half_only_on_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(half) |-> ($past(state) == ST_ADDR));

endmodule

// File: tb/spd_i2c_target_bench.sv
module spd_i2c_target_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] strap = 3'd0;
    logic [3:0] lock = 4'd0;
    logic       sda_pull;
    logic       sda_line;

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    spd_i2c_target u_spd_i2c_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (m_scl),
        .sda_in     (sda_line),
        .addr_strap (strap),
        .blk_lock   (lock),
        .sda_pull   (sda_pull)
    );

    int nchk = 0;
    int nfail = 0;

    logic [7:0] mdl [0:511];
    logic       mhalf;
    logic [7:0] mptr;

    // {op[1:0], half, ptr[7:0], len[4:0], base[7:0], lock[3:0]}; op 0 write, 1 read, 2 half select
    localparam int NV = 20;
    localparam logic [27:0] VEC [0:NV-1] = '{
        {2'd0, 1'b0, 8'h10, 5'd4,  8'h11, 4'h0},
        {2'd1, 1'b0, 8'h10, 5'd4,  8'h00, 4'h0},
        {2'd0, 1'b0, 8'h1C, 5'd6,  8'h40, 4'h0},
        {2'd1, 1'b0, 8'h10, 5'd16, 8'h00, 4'h0},
        {2'd0, 1'b0, 8'hFF, 5'd1,  8'h9A, 4'h0},
        {2'd1, 1'b0, 8'hFF, 5'd2,  8'h00, 4'h0},
        {2'd2, 1'b1, 8'h00, 5'd0,  8'h00, 4'h0},
        {2'd0, 1'b0, 8'h00, 5'd2,  8'hC0, 4'h0},
        {2'd0, 1'b0, 8'hF8, 5'd8,  8'h80, 4'h0},
        {2'd1, 1'b0, 8'hFE, 5'd4,  8'h00, 4'h0},
        {2'd0, 1'b0, 8'hF0, 5'd3,  8'h55, 4'h8},
        {2'd1, 1'b0, 8'hF0, 5'd16, 8'h00, 4'h8},
        {2'd0, 1'b0, 8'h20, 5'd2,  8'h66, 4'h8},
        {2'd1, 1'b0, 8'h20, 5'd2,  8'h00, 4'h8},
        {2'd2, 1'b0, 8'h00, 5'd0,  8'h00, 4'h0},
        {2'd1, 1'b0, 8'h1E, 5'd3,  8'h00, 4'h0},
        {2'd0, 1'b0, 8'h30, 5'd1,  8'h77, 4'h1},
        {2'd1, 1'b0, 8'h30, 5'd1,  8'h00, 4'h1},
        {2'd0, 1'b0, 8'hE0, 5'd16, 8'h01, 4'h0},
        {2'd1, 1'b0, 8'hE0, 5'd16, 8'h00, 4'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b0; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b1; qw(); qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; qw();
            m_scl = 1'b1; qw(); qw();
            m_scl = 1'b0; qw();
        end
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        acked = ~sda_line; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw();
            m_scl = 1'b1; qw();
            b[i] = sda_line; qw();
            m_scl = 1'b0; qw();
        end
        m_sda = ~give_ack; qw();
        m_scl = 1'b1; qw(); qw();
        m_scl = 1'b0; qw();
        m_sda = 1'b1;
    endtask

    function automatic logic [7:0] dev_byte(input logic rd);
        return {4'b1010, strap, rd};
    endfunction

    task automatic do_write(input logic [7:0] p, input int len, input logic [7:0] base, input string tag);
        logic a;
        bus_start();
        send_byte(dev_byte(1'b0), a); chk({tag, " address ack"}, a, 1'b1);
        send_byte(p, a);              chk({tag, " pointer ack"}, a, 1'b1);
        mptr = p;
        for (int i = 0; i < len; i++) begin
            logic [7:0] d;
            d = base + 8'(i);
            send_byte(d, a);
            chk({tag, " data ack"}, a, 1'b1);
            if (!lock[{mhalf, mptr[7]}]) mdl[{mhalf, mptr}] = d;
            mptr = {mptr[7:4], mptr[3:0] + 4'd1};
        end
        bus_stop();
    endtask

    task automatic cur_read(input int len, input string tag);
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(dev_byte(1'b1), a); chk({tag, " read address ack"}, a, 1'b1);
        for (int i = 0; i < len; i++) begin
            recv_byte(i != len - 1, d);
            chk({tag, " read data"}, d, mdl[{mhalf, mptr}]);
            mptr = mptr + 8'd1;
        end
        bus_stop();
    endtask

    task automatic rnd_read(input logic [7:0] p, input int len, input string tag);
        logic a;
        bus_start();
        send_byte(dev_byte(1'b0), a); chk({tag, " address ack"}, a, 1'b1);
        send_byte(p, a);              chk({tag, " pointer ack"}, a, 1'b1);
        bus_stop();
        mptr = p;
        cur_read(len, tag);
    endtask

    task automatic do_half(input logic h, input string tag);
        logic a;
        bus_start();
        send_byte({6'b011011, h, 1'b0}, a); chk({tag, " command ack"}, a, 1'b1);
        send_byte(8'h00, a);                chk({tag, " dummy 1 ack"}, a, 1'b1);
        send_byte(8'h00, a);                chk({tag, " dummy 2 ack"}, a, 1'b1);
        bus_stop();
        mhalf = h;
    endtask

    // R10 monitor: pull-down must not move while SCL has been high
    int   r10_bad = 0;
    logic pull_q = 1'b0;
    logic scl_hold = 1'b1;
    always @(negedge clk) begin
        if (m_scl && scl_hold && (sda_pull !== pull_q)) r10_bad++;
        pull_q   <= sda_pull;
        scl_hold <= m_scl;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] d;
        for (int i = 0; i < 512; i++) mdl[i] = 8'h00;
        mhalf = 1'b0;
        mptr  = 8'h00;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R7: reset state
        chk("R7 SDA released after reset", sda_pull, 1'b0);
        cur_read(2, "R7 reset pointer/half");

        // table walk
        for (int v = 0; v < NV; v++) begin
            logic [1:0] op;
            op   = VEC[v][27:26];
            lock = VEC[v][3:0];
            if (op == 2'd0)
                do_write(VEC[v][24:17], int'(VEC[v][16:12]), VEC[v][11:4],
                         (VEC[v][3:0] != 4'h0) ? "R6 locked-block write" : "R5 write");
            else if (op == 2'd1)
                rnd_read(VEC[v][24:17], int'(VEC[v][16:12]), "R3 R4 random/sequential read");
            else
                do_half(VEC[v][25], "R2 half select");
        end
        lock = 4'h0;

        // R8: NACK ends a read, next read continues
        rnd_read(8'h1C, 2, "R8 read before NACK");
        chk("R8 SDA released after NACK", sda_pull, 1'b0);
        cur_read(1, "R8 continued read");

        // R1: wrong device address ignored until START
        bus_start();
        send_byte(8'hA2, a); chk("R1 foreign address not acked", a, 1'b0);
        send_byte(8'h00, a); chk("R1 ignored until START", a, 1'b0);
        bus_stop();

        // R1: strap change moves the device address
        strap = 3'b101;
        bus_start();
        send_byte(8'hA0, a); chk("R1 old address not acked", a, 1'b0);
        bus_stop();
        rnd_read(8'h10, 2, "R1 strapped address read");

        // R2: half select independent of straps
        do_half(1'b1, "R2 half 1 with straps 101");
        rnd_read(8'h00, 2, "R2 half 1 data");
        do_half(1'b0, "R2 half 0 with straps 101");
        strap = 3'b000;

        // R9: partial byte aborted by START
        rnd_read(8'h12, 1, "R9 set pointer");
        bus_start();
        for (int i = 0; i < 4; i++) begin
            m_sda = ~i[0]; qw();
            m_scl = 1'b1; qw(); qw();
            m_scl = 1'b0; qw();
        end
        bus_start();
        send_byte(dev_byte(1'b1), a); chk("R9 address after abort acked", a, 1'b1);
        recv_byte(1'b0, d);
        chk("R9 data after abort", d, mdl[{mhalf, mptr}]);
        mptr = mptr + 8'd1;
        bus_stop();

        chk("R10 pull-down changes while SCL high", r10_bad, 0);

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule